// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the sampling tick that drives a UART's serial transmitter and receiver. An integer divisor sets the base length of one tick period in input clocks. A fractional stage then lengthens some of those periods, so that the average tick rate is the input clock divided by divisor × (1 + ADD/MUL). ADD and MUL are two 4-bit fraction fields. The line bit rate is one sixteenth of the tick rate. The block also gives a one-cycle strobe on every sixteenth tick, which marks one bit time.

Three write strobes load the configuration: one for the upper divisor byte, one for the lower divisor byte, and one for the fraction pair. The divisor bytes are accepted only while a separate divisor-access input is high. The fraction fields have no such gate. Every accepted write restarts the timing from a clean phase. An illegal fraction pair does not stop the block: the fraction is bypassed and a sticky error flag is raised, so the condition can be found later.

Top module: `baud_frac_gen`

## Requirements
- R1: The divisor is upper_byte × 256 + lower_byte. With ADD = 0, each tick period lasts exactly divisor clock cycles, and `os_tick` is high for one cycle at the end of each period.
- R2: With a legal fraction pair, an accumulator starts at 0 after a restart or an enable. A period is stretched to 2 × divisor clocks when accumulator + ADD ≥ MUL. The accumulator then takes the value (accumulator + ADD − MUL). Otherwise the period lasts divisor clocks and the accumulator takes (accumulator + ADD). The result is that exactly ADD of every MUL consecutive periods are stretched.
- R3: A fraction pair is illegal when MUL = 0 or ADD ≥ MUL. While the stored pair is illegal, every period lasts divisor clocks and `cfg_err` becomes 1.
- R4: Once `cfg_err` is 1, it stays 1 through later legal writes until reset.
- R5: While the divisor is 0, `os_tick` and `bit_tick` stay low.
- R6: A strobe on a divisor byte has no effect while `div_access` is 0. The stored divisor, and with it the tick period, stays unchanged.
- R7: Any accepted write clears the period counter, the accumulator and the tick count at the end of the write cycle. The first tick afterwards falls exactly one period length after the write cycle.
- R8: `bit_tick` is high together with every sixteenth `os_tick`, counted from the last restart or enable, and is never high without `os_tick`.
- R9: While `en` is 0, no tick is produced and all counters are held at zero. After `en` rises, the first tick comes at the end of the first full period, counting the cycle in which `en` is first high as cycle 1.
- R10: After the synchronous reset, the divisor is 0, MUL is 1, ADD is 0, `cfg_err` is 0 and both ticks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for tick generation |
| div_access | input | 1 | Allows divisor byte writes |
| div_hi_we | input | 1 | Write strobe, upper divisor byte |
| div_hi_in | input | 8 | Upper divisor byte |
| div_lo_we | input | 1 | Write strobe, lower divisor byte |
| div_lo_in | input | 8 | Lower divisor byte |
| frac_we | input | 1 | Write strobe, fraction pair |
| frac_mul_in | input | 4 | Fraction denominator MUL |
| frac_add_in | input | 4 | Fraction numerator ADD |
| os_tick | output | 1 | One-cycle oversample tick |
| bit_tick | output | 1 | One-cycle strobe on every sixteenth tick |
| cfg_err | output | 1 | Sticky illegal-fraction flag |

## Verification
The assertions check the following on every cycle:
- `cfg_err` never clears.
- A divisor strobe without access leaves the divisor unchanged.
- A restart zeroes the counter.
- The counter stays below twice the divisor.
- The accumulator stays below MUL while the fraction is legal.
- There is no tick while the block is disabled or the divisor is 0.
- `bit_tick` never appears without `os_tick`.

Some behaviour only the bench scenarios can show: the exact length of each period under several divisor and fraction settings, where the stretched periods fall, the one-period latency after a restart or an enable, and the sixteen-tick cadence of the bit strobe.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int FRAC_W = 4;
    localparam int CNT_W  = DIV_W + 1;
    localparam int ACC_W  = FRAC_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0]  divisor;
        logic [FRAC_W-1:0] mul;
        logic [FRAC_W-1:0] add;
    } baud_cfg_t;

    localparam baud_cfg_t CFG_RESET = '{divisor: '0, mul: FRAC_W'(1), add: '0};

    function automatic logic frac_legal(input logic [FRAC_W-1:0] m,
                                        input logic [FRAC_W-1:0] a);
        return (m != '0) && (a < m);
    endfunction

    function automatic logic [CNT_W-1:0] period_last(input logic [DIV_W-1:0] d,
                                                     input logic stretch);
        logic [CNT_W-1:0] len;
        len = stretch ? {d, 1'b0} : {1'b0, d};
        return len - CNT_W'(1);
    endfunction
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              div_access,
    input  logic              div_hi_we,
    input  logic [BYTE_W-1:0] div_hi_in,
    input  logic              div_lo_we,
    input  logic [BYTE_W-1:0] div_lo_in,
    input  logic              frac_we,
    input  logic [FRAC_W-1:0] frac_mul_in,
    input  logic [FRAC_W-1:0] frac_add_in,
    output baud_cfg_t         cfg_o,
    output logic              restart_o,
    output logic              cfg_err_o
);
    baud_cfg_t cfg_q;
    logic      err_q;
    logic      hi_ok, lo_ok;

    assign hi_ok     = div_hi_we && div_access;
    assign lo_ok     = div_lo_we && div_access;
    assign restart_o = hi_ok || lo_ok || frac_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else begin
            if (hi_ok) cfg_q.divisor[DIV_W-1:BYTE_W] <= div_hi_in;
            if (lo_ok) cfg_q.divisor[BYTE_W-1:0]     <= div_lo_in;
            if (frac_we) begin
                cfg_q.mul <= frac_mul_in;
                cfg_q.add <= frac_add_in;
            end
            err_q <= err_q | ~frac_legal(cfg_q.mul, cfg_q.add);
        end
    end

    assign cfg_o     = cfg_q;
    assign cfg_err_o = err_q;

    // R4: the error flag is sticky
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R6: divisor unchanged when access is off
    assert_div_gated_R6: assert property (@(posedge clk) disable iff (rst)
        !div_access |=> $stable(cfg_q.divisor));
endmodule

// File: rtl/baud_period_gen.sv
module baud_period_gen
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      restart,
    input  baud_cfg_t cfg_i,
    output logic      tick_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [ACC_W-1:0]  acc_sum;
    logic              use_frac;
    logic              stretch;
    logic [CNT_W-1:0]  last;
    logic [FRAC_W-1:0] acc_next;

    always_comb begin
        use_frac = frac_legal(cfg_i.mul, cfg_i.add);
        acc_sum  = {1'b0, acc_q} + {1'b0, cfg_i.add};
        stretch  = use_frac && (acc_sum >= {1'b0, cfg_i.mul});
        if (stretch) acc_next = FRAC_W'(acc_sum - {1'b0, cfg_i.mul});
        else         acc_next = FRAC_W'(acc_sum);
        last     = period_last(cfg_i.divisor, stretch);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
            if (use_frac) acc_q <= acc_next;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick_o = !clear && (cnt_q == last);

    // R7: a restart zeroes the period counter
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));

    // R2: counter never runs past a stretched period
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.divisor != '0) |-> (cnt_q < {cfg_i.divisor, 1'b0}));

    // R2: accumulator stays below MUL while the fraction is legal
    assert_acc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        use_frac |-> (acc_q < cfg_i.mul));
endmodule

// File: rtl/baud_bit_strobe.sv
module baud_bit_strobe #(
    parameter int OVERSAMPLE = 16,
    parameter bit BIT_EN     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick_i,
    output logic bit_o
);
    localparam int TCNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

    generate
        if (BIT_EN) begin : g_strobe
            logic [TCNT_W-1:0] tcnt_q;
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    tcnt_q <= '0;
                end else if (tick_i) begin
                    if (tcnt_q == TCNT_W'(OVERSAMPLE - 1)) tcnt_q <= '0;
                    else                                    tcnt_q <= tcnt_q + TCNT_W'(1);
                end
            end
            assign bit_o = tick_i && (tcnt_q == TCNT_W'(OVERSAMPLE - 1));
        end else begin : g_none
            assign bit_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import baud_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter bit BIT_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              div_access,
    input  logic              div_hi_we,
    input  logic [BYTE_W-1:0] div_hi_in,
    input  logic              div_lo_we,
    input  logic [BYTE_W-1:0] div_lo_in,
    input  logic              frac_we,
    input  logic [FRAC_W-1:0] frac_mul_in,
    input  logic [FRAC_W-1:0] frac_add_in,
    output logic              os_tick,
    output logic              bit_tick,
    output logic              cfg_err
);
    baud_cfg_t cfg;
    logic      restart;
    logic      clear;

    baud_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .div_access (div_access),
        .div_hi_we  (div_hi_we),
        .div_hi_in  (div_hi_in),
        .div_lo_we  (div_lo_we),
        .div_lo_in  (div_lo_in),
        .frac_we    (frac_we),
        .frac_mul_in(frac_mul_in),
        .frac_add_in(frac_add_in),
        .cfg_o      (cfg),
        .restart_o  (restart),
        .cfg_err_o  (cfg_err)
    );

    assign clear = restart || !en || (cfg.divisor == '0);

    baud_period_gen u_period (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .restart(restart),
        .cfg_i  (cfg),
        .tick_o (os_tick)
    );

    baud_bit_strobe #(.OVERSAMPLE(OVERSAMPLE), .BIT_EN(BIT_EN)) u_bits (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .tick_i(os_tick),
        .bit_o (bit_tick)
    );

    // R8: bit strobe only with a tick
    assert_bit_with_tick_R8: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick);

    // R9: no tick while disabled
    assert_no_tick_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en |-> !os_tick);

    // R5: no tick with a zero divisor
    assert_no_tick_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg.divisor == '0) |-> !(os_tick || bit_tick));
endmodule

// File: tb/baud_frac_gen_tb.sv
`timescale 1ns/1ps
module baud_frac_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, div_access = 1'b0;
    logic       div_hi_we = 1'b0, div_lo_we = 1'b0, frac_we = 1'b0;
    logic [7:0] div_hi_in = '0, div_lo_in = '0;
    logic [3:0] frac_mul_in = '0, frac_add_in = '0;
    logic       os_tick, bit_tick, cfg_err;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    int gap = 0;
    int tidx = 0;

    always #2.5 clk = ~clk;

    baud_frac_gen u_dut (
        .clk(clk), .rst(rst), .en(en), .div_access(div_access),
        .div_hi_we(div_hi_we), .div_hi_in(div_hi_in),
        .div_lo_we(div_lo_we), .div_lo_in(div_lo_in),
        .frac_we(frac_we), .frac_mul_in(frac_mul_in), .frac_add_in(frac_add_in),
        .os_tick(os_tick), .bit_tick(bit_tick), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_div(input logic [7:0] hi, input logic [7:0] lo, input logic acc);
        step();
        div_access = acc; div_hi_we = 1'b1; div_hi_in = hi;
        step();
        div_hi_we = 1'b0; div_lo_we = 1'b1; div_lo_in = lo;
        step();
        div_lo_we = 1'b0; div_access = 1'b0;
    endtask

    task automatic wr_frac(input logic [3:0] m, input logic [3:0] a);
        step();
        frac_we = 1'b1; frac_mul_in = m; frac_add_in = a;
        step();
        frac_we = 1'b0;
    endtask

    // driver: reference model of the period sequence (R1, R2, R3)
    task automatic run_case(input int d, input int m, input int a, input int n);
        int  acc;
        bit  legal;
        acc   = 0;
        legal = (m != 0) && (a < m);
        for (int i = 0; i < n; i++) begin
            if (legal && (acc + a >= m)) begin
                exp_q.push_back(2 * d);
                acc = acc + a - m;
            end else begin
                exp_q.push_back(d);
                if (legal) acc = acc + a;
            end
        end
        step();
        en = 1'b1; mon_on = 1'b1;
        wait (exp_q.size() == 0);
        step();
        en = 1'b0; mon_on = 1'b0;
    endtask

    // monitor: measures each period and the bit strobe cadence
    always @(negedge clk) begin
        if (!mon_on) begin
            gap  = 0;
            tidx = 0;
        end else if (en) begin
            gap++;
            if (os_tick) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected tick", gap, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(gap == e, "R1/R2/R3/R9 period length", gap, e);
                end
                check(bit_tick == ((tidx % 16) == 15), "R8 bit strobe", int'(bit_tick),
                      int'((tidx % 16) == 15));
                tidx++;
                gap = 0;
            end else begin
                check(!bit_tick, "R8 strobe without tick", int'(bit_tick), 0);
            end
        end
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        check(!os_tick && !bit_tick, "R10 ticks low after reset", int'(os_tick), 0);
        check(!cfg_err, "R10 error flag clear", int'(cfg_err), 0);
        // reset divisor is zero: enabling gives nothing
        step();
        en = 1'b1;
        n = 0;
        repeat (40) begin @(negedge clk); if (os_tick) n++; end
        check(n == 0, "R10 zero divisor after reset", n, 0);
        step();
        en = 1'b0;

        wr_div(8'h00, 8'h06, 1'b1);
        run_case(6, 1, 0, 40);                          // R1
        wr_div(8'h01, 8'h02, 1'b1);
        run_case(258, 1, 0, 18);                        // R1 upper byte
        wr_div(8'h00, 8'h03, 1'b1);
        wr_frac(4'd4, 4'd1);
        run_case(3, 4, 1, 40);                          // R2
        wr_div(8'h00, 8'h02, 1'b1);
        wr_frac(4'd15, 4'd14);
        run_case(2, 15, 14, 34);                        // R2
        wr_div(8'h00, 8'h01, 1'b1);
        wr_frac(4'd3, 4'd2);
        run_case(1, 3, 2, 33);                          // R2

        // R6: divisor strobes without access are ignored
        wr_frac(4'd1, 4'd0);
        wr_div(8'h00, 8'h05, 1'b1);
        wr_div(8'h10, 8'h01, 1'b0);
        run_case(5, 1, 0, 20);

        // R7: write mid-period restarts the counter
        wr_div(8'h00, 8'h07, 1'b1);
        step();
        en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!os_tick && n < 50);
        step();
        div_access = 1'b1; div_lo_we = 1'b1; div_lo_in = 8'h07;
        step();
        div_lo_we = 1'b0; div_access = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!os_tick && n < 50);
        check(n == 7, "R7 first tick after restart", n, 7);

        // R9: disabled gives no ticks
        step();
        en = 1'b0;
        n = 0;
        repeat (40) begin @(negedge clk); if (os_tick || bit_tick) n++; end
        check(n == 0, "R9 no ticks while disabled", n, 0);

        // R5: zero divisor written while running
        step();
        en = 1'b1;
        wr_div(8'h00, 8'h00, 1'b1);
        n = 0;
        repeat (60) begin @(negedge clk); if (os_tick || bit_tick) n++; end
        check(n == 0, "R5 zero divisor stops ticks", n, 0);
        step();
        en = 1'b0;

        // R3: illegal fraction bypassed and flagged
        check(!cfg_err, "R3 flag clear before illegal pair", int'(cfg_err), 0);
        wr_div(8'h00, 8'h04, 1'b1);
        wr_frac(4'd3, 4'd5);
        run_case(4, 3, 5, 20);
        check(cfg_err, "R3 flag set for ADD>=MUL", int'(cfg_err), 1);

        // R4: flag stays through a legal write, clears on reset
        wr_frac(4'd4, 4'd1);
        repeat (4) step();
        check(cfg_err, "R4 flag sticky", int'(cfg_err), 1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        @(negedge clk);
        check(!cfg_err, "R4 flag cleared by reset", int'(cfg_err), 0);

        // R3: MUL of zero also illegal
        wr_frac(4'd0, 4'd0);
        repeat (3) step();
        check(cfg_err, "R3 flag set for MUL=0", int'(cfg_err), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule